// File: doc/BRIEF.md
# BFloat16 Clamp Lane

This block limits one BFloat16 value to a per-lane window. The window is given by a lower bound and an upper bound. It first takes the number-preferring maximum of the value and the lower bound. It then takes the number-preferring minimum of that result and the upper bound. Because no arithmetic is done, nothing is rounded. The lane only orders, selects and quiets its operands.

NaN handling is fixed, with one exception: a single mode input decides whether NaN results carry the payload of an operand or are replaced by the canonical default NaN. An invalid-operation flag reports when any of the three inputs is a signalling NaN. The result and the flag are registered once, so a wide datapath can place many copies of this lane side by side behind one pipeline stage.

Top module: `bf16_clamp_lane`

## Requirements
- R1: One clock edge after the inputs are sampled, `res_o` equals minnum(maxnum(`val_i`, `lo_i`), `hi_i`), with the maximum taken first. When no input is a NaN, the result is always one of the three inputs.
- R2: Both stages order negative zero (0x8000) strictly below positive zero (0x0000).
- R3: When one operand of a stage is a quiet NaN and the other is a number, that stage returns the number.
- R4: With `dflt_nan_en` = 0, a stage gives a NaN result if either operand is a signalling NaN or both operands are NaN. That result is the first signalling NaN operand, or if there is none, the first NaN operand, with fraction bit 6 forced to 1. Stage one takes `val_i` before `lo_i`. Stage two takes the stage-one result before `hi_i`.
- R5: With `dflt_nan_en` = 1, under the same conditions, a stage returns 0x7FC0.
- R6: `inv_o` is 1 exactly when at least one of `val_i`, `lo_i`, `hi_i` was a signalling NaN in the sampled cycle.
- R7: A NaN has exponent bits [14:7] all ones and a nonzero fraction [6:0]. It is quiet when bit 6 is 1 and signalling otherwise. Infinities (0x7F80, 0xFF80) are numbers.
- R8: Subnormal operands are ordered by their exact value and are never flushed to zero. Negative numbers are ordered by descending magnitude.
- R9: While `rst_n` is low at a rising edge, `res_o` and `inv_o` become 0 at that edge.
- R10: `res_o` is never a signalling NaN.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dflt_nan_en | input | 1 | 1 selects the default NaN for NaN results |
| val_i | input | 16 | Value to clamp |
| lo_i | input | 16 | Lower bound |
| hi_i | input | 16 | Upper bound |
| res_o | output | 16 | Registered clamped result |
| inv_o | output | 1 | Registered invalid-operation flag |

## Verification
Both `res_o` and `inv_o` are due exactly one rising edge after an input set is applied. Nothing else in the lane holds state, so each input set stands on its own. The bench applies each set just after a falling edge and reads both outputs at the next falling edge, so exactly one rising edge lies between stimulus and sample. The bench sweeps every triple drawn from a list of 24 special encodings under both NaN modes, which gives 27,648 sets. It compares each result with a sign-and-magnitude reference model written from the requirements.

// File: rtl/bf16_clamp_pkg.sv
// Package: shared classification type for the clamp lane.
// Assumes: IEEE-style layout {sign, exponent, fraction}.
package bf16_clamp_pkg;

    // Classification of one operand, produced by bf16_classify.
    typedef struct packed {
        logic is_nan;   // exponent all ones, fraction nonzero
        logic is_snan;  // NaN with top fraction bit clear
        logic is_quiet; // NaN with top fraction bit set
    } fp_class_t;

endpackage

// File: rtl/bf16_classify.sv
// Module: bf16_classify
// Classifies one floating-point operand as NaN, signalling NaN or quiet NaN.
// It also builds an unsigned order key whose integer order matches the
// numeric order of the operand (negative zero sorts below positive zero).
// Assumes: no flushing of subnormals; the key is meaningless for NaNs.
module bf16_classify
    import bf16_clamp_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 7,
    localparam int W     = 1 + EXP_W + FRAC_W
) (
    input  logic [W-1:0] x,
    output fp_class_t    cls,
    output logic [W-1:0] key
);

    logic exp_ones;
    logic frac_nz;

    // Decode the exponent and fraction fields.
    always_comb begin
        exp_ones = &x[W-2:FRAC_W];
        frac_nz  = |x[FRAC_W-1:0];
    end

    // Form the NaN classes from the field decode.
    always_comb begin
        cls.is_nan   = exp_ones && frac_nz;
        cls.is_quiet = exp_ones && frac_nz && x[FRAC_W-1];
        cls.is_snan  = exp_ones && frac_nz && !x[FRAC_W-1];
    end

    // Order key: invert negatives, set the top bit for positives.
    always_comb begin
        if (x[W-1]) key = ~x;
        else        key = {1'b1, x[W-2:0]};
    end

endmodule

// File: rtl/bf16_minmax_num.sv
// Module: bf16_minmax_num
// One number-preferring minimum or maximum stage (IS_MAX selects which).
// A quiet NaN loses against a number. A signalling NaN, or two NaNs,
// gives a NaN: either the first signalling NaN (else the first NaN),
// quieted, or the default NaN when dflt_nan_en is set.
// Assumes: operand a is "first" for NaN selection.
module bf16_minmax_num
    import bf16_clamp_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 7,
    parameter bit IS_MAX = 1'b1,
    localparam int W     = 1 + EXP_W + FRAC_W
) (
    input  logic         dflt_nan_en,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y,
    output logic         snan_seen
);

    localparam logic [W-1:0] QUIET_BIT = W'(1) << (FRAC_W - 1);
    localparam logic [W-1:0] DFLT_NAN  = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    logic [W-1:0] opnd [2];
    fp_class_t    cls  [2];
    logic [W-1:0] key  [2];

    assign opnd[0] = a;
    assign opnd[1] = b;

    // One classifier per operand.
    for (genvar g = 0; g < 2; g++) begin : g_cls
        bf16_classify #(
            .EXP_W (EXP_W),
            .FRAC_W(FRAC_W)
        ) i_cls (
            .x  (opnd[g]),
            .cls(cls[g]),
            .key(key[g])
        );
    end

    logic pick_a;

    // The parameter picks the comparison direction.
    if (IS_MAX) begin : g_max
        assign pick_a = key[0] >= key[1];
    end else begin : g_min
        assign pick_a = key[0] <= key[1];
    end

    logic         nan_out;
    logic [W-1:0] nan_src;

    // Decide whether the result must be a NaN and which operand feeds it.
    always_comb begin
        nan_out = cls[0].is_snan || cls[1].is_snan || (cls[0].is_nan && cls[1].is_nan);
        if (cls[0].is_snan)      nan_src = a;
        else if (cls[1].is_snan) nan_src = b;
        else if (cls[0].is_nan)  nan_src = a;
        else                     nan_src = b;
    end

    // Select the stage result.
    always_comb begin
        if (nan_out)            y = dflt_nan_en ? DFLT_NAN : (nan_src | QUIET_BIT);
        else if (cls[0].is_nan) y = b;
        else if (cls[1].is_nan) y = a;
        else                    y = pick_a ? a : b;
    end

    // Report a signalling operand to the invalid flag.
    assign snan_seen = cls[0].is_snan || cls[1].is_snan;

endmodule

// File: rtl/bf16_clamp_lane.sv
// Module: bf16_clamp_lane (top)
// Clamps val_i between lo_i and hi_i as minnum(maxnum(val_i, lo_i), hi_i),
// then registers the result and the invalid flag.
// Assumes: synchronous active-low reset; latency of one clock.
module bf16_clamp_lane #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 7,
    localparam int W     = 1 + EXP_W + FRAC_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         dflt_nan_en,
    input  logic [W-1:0] val_i,
    input  logic [W-1:0] lo_i,
    input  logic [W-1:0] hi_i,
    output logic [W-1:0] res_o,
    output logic         inv_o
);

    logic [W-1:0] floor_res;
    logic [W-1:0] clamp_res;
    logic         inv_lo_stage;
    logic         inv_hi_stage;

    // Stage one: raise the value to the lower bound.
    bf16_minmax_num #(
        .EXP_W (EXP_W),
        .FRAC_W(FRAC_W),
        .IS_MAX(1'b1)
    ) i_floor (
        .dflt_nan_en(dflt_nan_en),
        .a          (val_i),
        .b          (lo_i),
        .y          (floor_res),
        .snan_seen  (inv_lo_stage)
    );

    // Stage two: cap the stage-one result at the upper bound.
    bf16_minmax_num #(
        .EXP_W (EXP_W),
        .FRAC_W(FRAC_W),
        .IS_MAX(1'b0)
    ) i_ceil (
        .dflt_nan_en(dflt_nan_en),
        .a          (floor_res),
        .b          (hi_i),
        .y          (clamp_res),
        .snan_seen  (inv_hi_stage)
    );

    // Output register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_o <= '0;
            inv_o <= 1'b0;
        end else begin
            res_o <= clamp_res;
            inv_o <= inv_lo_stage | inv_hi_stage;
        end
    end

endmodule

// File: rtl/bf16_clamp_lane_chk.sv
// Module: bf16_clamp_lane_chk
// Port-level assertions for bf16_clamp_lane, bound into every instance.
module bf16_clamp_lane_chk #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 7,
    localparam int W     = 1 + EXP_W + FRAC_W
) (
    input logic         clk,
    input logic         rst_n,
    input logic         dflt_nan_en,
    input logic [W-1:0] val_i,
    input logic [W-1:0] lo_i,
    input logic [W-1:0] hi_i,
    input logic [W-1:0] res_o,
    input logic         inv_o
);

    localparam logic [W-1:0] DNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    function automatic logic f_nan(input logic [W-1:0] x);
        return (&x[W-2:FRAC_W]) && (|x[FRAC_W-1:0]);
    endfunction

    function automatic logic f_snan(input logic [W-1:0] x);
        return f_nan(x) && !x[FRAC_W-1];
    endfunction

    logic any_snan;
    logic any_nan;
    assign any_snan = f_snan(val_i) || f_snan(lo_i) || f_snan(hi_i);
    assign any_nan  = f_nan(val_i) || f_nan(lo_i) || f_nan(hi_i);

    // R9
    rst_clear_chk: assert property (@(posedge clk) !rst_n |=> (res_o == '0 && !inv_o));

    // R6
    inv_set_chk: assert property (@(posedge clk) disable iff (!rst_n) any_snan |=> inv_o);

    // R6
    inv_clr_chk: assert property (@(posedge clk) disable iff (!rst_n) !any_snan |=> !inv_o);

    // R10
    no_snan_out_chk: assert property (@(posedge clk) disable iff (!rst_n) !f_snan(res_o));

    // R5
    dflt_nan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dflt_nan_en && (f_snan(hi_i) || (f_nan(val_i) && f_nan(lo_i) && f_nan(hi_i))))
        |=> res_o == DNAN);

    // R3
    qnan_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!f_nan(val_i) && f_nan(lo_i) && !f_snan(lo_i) && f_nan(hi_i) && !f_snan(hi_i))
        |=> res_o == $past(val_i));

    // R1
    pick_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !any_nan |=> (res_o == $past(val_i) || res_o == $past(lo_i) || res_o == $past(hi_i)));

endmodule

bind bf16_clamp_lane bf16_clamp_lane_chk #(
    .EXP_W (EXP_W),
    .FRAC_W(FRAC_W)
) i_clamp_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .dflt_nan_en(dflt_nan_en),
    .val_i      (val_i),
    .lo_i       (lo_i),
    .hi_i       (hi_i),
    .res_o      (res_o),
    .inv_o      (inv_o)
);

// File: tb/test_bf16_clamp_lane.sv
// Bench: sweeps all triples from a list of special encodings in both NaN modes
// and compares with a sign/magnitude reference model.
module test_bf16_clamp_lane;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dflt_nan_en = 1'b0;
    logic [15:0] val_i = '0;
    logic [15:0] lo_i = '0;
    logic [15:0] hi_i = '0;
    logic [15:0] res_o;
    logic        inv_o;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    bf16_clamp_lane i_bf16_clamp_lane (
        .clk        (clk),
        .rst_n      (rst_n),
        .dflt_nan_en(dflt_nan_en),
        .val_i      (val_i),
        .lo_i       (lo_i),
        .hi_i       (hi_i),
        .res_o      (res_o),
        .inv_o      (inv_o)
    );

    localparam int NV = 24;

    function automatic logic [15:0] pat(input int i);
        case (i)
            0:  return 16'h0000;  1:  return 16'h8000;
            2:  return 16'h0001;  3:  return 16'h8001;
            4:  return 16'h007F;  5:  return 16'h807F;
            6:  return 16'h0080;  7:  return 16'h8080;
            8:  return 16'h3F80;  9:  return 16'hBF80;
            10: return 16'h4000;  11: return 16'hC000;
            12: return 16'h7F7F;  13: return 16'hFF7F;
            14: return 16'h7F80;  15: return 16'hFF80;
            16: return 16'h7FC0;  17: return 16'hFFC5;
            18: return 16'h7F81;  19: return 16'hFF83;
            20: return 16'h7FA0;  21: return 16'h3F81;
            22: return 16'hBF81;  default: return 16'h7FFF;
        endcase
    endfunction

    // R7 encodings
    function automatic bit is_nan(input logic [15:0] x);
        return x[14:7] == 8'hFF && x[6:0] != 7'd0;
    endfunction
    function automatic bit is_snan(input logic [15:0] x);
        return is_nan(x) && x[6] == 1'b0;
    endfunction

    // Strict numeric less-than, negative zero below positive zero (R2, R8).
    function automatic bit less(input logic [15:0] a, input logic [15:0] b);
        if (a[15] != b[15]) return a[15];
        if (!a[15])         return a[14:0] < b[14:0];
        return a[14:0] > b[14:0];
    endfunction

    function automatic logic [15:0] ref_stage(input logic [15:0] a, input logic [15:0] b,
                                              input bit dn, input bit want_max);
        if (is_snan(a) || is_snan(b) || (is_nan(a) && is_nan(b))) begin
            if (dn)              return 16'h7FC0;
            if (is_snan(a))      return a | 16'h0040;
            if (is_snan(b))      return b | 16'h0040;
            if (is_nan(a))       return a | 16'h0040;
            return b | 16'h0040;
        end
        if (is_nan(a)) return b;
        if (is_nan(b)) return a;
        if (want_max) return less(a, b) ? b : a;
        return less(b, a) ? b : a;
    endfunction

    task automatic check(input bit ok, input string req, input logic [15:0] act,
                         input logic [15:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h (val=%h lo=%h hi=%h dn=%0b)",
                     req, act, exp, val_i, lo_i, hi_i, dflt_nan_en);
        end
    endtask

    function automatic string tag_of(input logic [15:0] v, input logic [15:0] l,
                                     input logic [15:0] h, input bit dn);
        bit anyn = is_nan(v) || is_nan(l) || is_nan(h);
        bit anys = is_snan(v) || is_snan(l) || is_snan(h);
        if (anyn && dn)                        return "R5";
        if (anys || (is_nan(v) && is_nan(l))) return "R4 R7";
        if (anyn)                              return "R3";
        if (v[14:0] == 0 || l[14:0] == 0 || h[14:0] == 0) return "R2";
        if (v[14:7] == 0 || l[14:7] == 0 || h[14:7] == 0) return "R8";
        return "R1";
    endfunction

    initial begin
        #(4 * 200000);
        bad++;
        total++;
        $display("watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R9: reset with busy inputs clears both outputs.
        @(negedge clk);
        val_i = 16'h7F81; lo_i = 16'h3F80; hi_i = 16'hFF83; dflt_nan_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check(res_o == 16'h0000, "R9 res", res_o, 16'h0000);
        check(inv_o == 1'b0, "R9 inv", {15'd0, inv_o}, 16'h0000);
        rst_n = 1'b1;

        for (int d = 0; d < 2; d++) begin
            for (int i = 0; i < NV; i++) begin
                for (int j = 0; j < NV; j++) begin
                    for (int k = 0; k < NV; k++) begin
                        logic [15:0] exp_r;
                        bit          exp_i;
                        dflt_nan_en = d[0];
                        val_i = pat(i);
                        lo_i  = pat(j);
                        hi_i  = pat(k);
                        exp_r = ref_stage(ref_stage(val_i, lo_i, d[0], 1'b1), hi_i, d[0], 1'b0);
                        exp_i = is_snan(val_i) || is_snan(lo_i) || is_snan(hi_i);
                        @(posedge clk);
                        @(negedge clk);
                        check(res_o == exp_r, tag_of(val_i, lo_i, hi_i, d[0]), res_o, exp_r);
                        check(inv_o == exp_i, "R6", {15'd0, inv_o}, {15'd0, exp_i});
                        check(!is_snan(res_o), "R10", res_o, 16'h7FC0);
                    end
                end
            end
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule